// File: doc/BRIEF.md
# Critical-Word-First Line Fill Engine

This block is the memory-facing half of a nonblocking data cache. Requests come in from the cache's miss handler one at a time. Each one is a line refill for a load, a line refill for a store, a dirty-line write-back or a single uncached load. The block turns each request into word-sized transactions on the system bus. Refills begin at the word the processor is waiting for and wrap around the line. Write-back words are read from the data array.

Read data comes back in request order. A tracking queue remembers what each outstanding read was for. On the first returning word of a load, the receiver wakes the processor with the data and the load's metadata. On the first word of a store refill, it merges the store bytes into that word. On the last word it writes the tag and the line status. The bus side has only one data-array port, and incoming read data always takes it. Write-back beats therefore wait for cycles with no response.

Top module: `line_fill_engine`

## Requirements
- R1: Request kinds are encoded 0 = load refill, 1 = store refill, 2 = write-back, 3 = uncached load. A refill (kind 0 or 1) issues 8 read beats. Beat i carries the word address {tag, frame, (crit + i) mod 8}, where crit is the requested word. A beat holds its address until `bus_ready` is high.
- R2: A write-back issues 8 write beats for words 0 to 7 in order, whatever the request's word field holds. Each beat drives `da_addr` = {frame, word} and sends `bus_wdata` equal to `da_rdata`.
- R3: A write-back beat is never presented in a cycle with `rsp_valid` high, and it resumes once `rsp_valid` is low. Responses arriving during a write-back are still written to the data array in that same cycle.
- R4: On the first response word of a load refill or an uncached load, `cpl_valid` is high in that cycle. `cpl_data` equals the response word and `cpl_meta` equals the metadata of the oldest outstanding read. No other response word raises `cpl_valid`.
- R5: Response beat i of a refill writes the data array at {frame, (crit + i) mod 8}. Every word of the line is therefore written exactly once.
- R6: On the last word of a load refill, `tag_we` is high with the request's frame and tag and `tag_dirty` = 0. This write sets valid and clears pending.
- R7: On a store refill, the first word written is the response word with byte k (bits 8k+7..8k) replaced by store byte k wherever store enable bit k is set. A store refill raises no `cpl_valid`. Its last word raises `tag_we` with `tag_dirty` = 1.
- R8: An uncached load issues exactly one read beat at {tag, frame, word}. Its response completes the load and writes neither the data array nor the tag.
- R9: Up to 32 reads may be outstanding, and they are retired in request order. While 32 are outstanding, a read request sees `req_ready` low until one response retires.
- R10: During reset, `bus_valid`, `cpl_valid`, `da_we` and `tag_we` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | Request kind (see R1) |
| req_tag | input | 20 | Line tag |
| req_frame | input | 6 | Cache frame index |
| req_word | input | 3 | Critical word (uncached: word offset) |
| req_meta | input | 8 | Load metadata returned on completion |
| req_sdata | input | 32 | Store data for a store refill |
| req_sbe | input | 4 | Store byte enables |
| bus_valid | output | 1 | Bus beat presented |
| bus_ready | input | 1 | Bus takes the beat |
| bus_write | output | 1 | Beat is a write |
| bus_addr | output | 29 | Word address {tag, frame, word} |
| bus_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data returning |
| rsp_data | input | 32 | Returned word |
| da_addr | output | 9 | Data array location {frame, word} |
| da_we | output | 1 | Data array write |
| da_wdata | output | 32 | Data array write data |
| da_rdata | input | 32 | Data array read data (same cycle) |
| tag_we | output | 1 | Tag and status write |
| tag_frame | output | 6 | Frame being written |
| tag_value | output | 20 | Tag written |
| tag_dirty | output | 1 | Dirty bit written |
| cpl_valid | output | 1 | Load completion to processor |
| cpl_data | output | 32 | Load data |
| cpl_meta | output | 8 | Load metadata |

## Verification
The bench sweeps every critical word position for both load and store refills, with a stalling ready pattern. A wrong wrap would repeat or skip a line word, and an early or late store merge would corrupt a word other than the critical one. A write-back runs while refill data arrives every other cycle. A design that failed to yield the port would either present write beats alongside response data or drop response writes. The tracking queue is driven to 32 entries with distinct metadata. A design with an off-by-one full flag would accept a 33rd read or stall at 31, and one with wrong ordering would return metadata to the wrong load.

// File: rtl/fill_pkg.sv
package fill_pkg;
    localparam int LINE_WORDS  = 8;
    localparam int WORD_W      = 32;
    localparam int FRAME_COUNT = 64;
    localparam int TAG_W       = 20;
    localparam int META_W      = 8;
    localparam int TRACK_DEPTH = 32;

    localparam int OFS_W   = $clog2(LINE_WORDS);
    localparam int FRAME_W = $clog2(FRAME_COUNT);
    localparam int BE_W    = WORD_W / 8;
    localparam int LOC_W   = FRAME_W + OFS_W;
    localparam int ADDR_W  = TAG_W + LOC_W;

    typedef enum logic [1:0] {
        K_LOAD_FILL  = 2'd0,
        K_STORE_FILL = 2'd1,
        K_WRITEBACK  = 2'd2,
        K_IO_LOAD    = 2'd3
    } fill_kind_e;

    typedef struct packed {
        fill_kind_e          kind;
        logic [TAG_W-1:0]    tag;
        logic [FRAME_W-1:0]  frame;
        logic [OFS_W-1:0]    word;
        logic [META_W-1:0]   meta;
        logic [WORD_W-1:0]   sdata;
        logic [BE_W-1:0]     sbe;
    } fill_req_t;

    function automatic logic kind_reads(fill_kind_e k);
        return k != K_WRITEBACK;
    endfunction
endpackage

// File: rtl/fill_track_fifo.sv
module fill_track_fifo
    import fill_pkg::*;
#(
    parameter int DEPTH = TRACK_DEPTH
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  fill_req_t push_data,
    input  logic      pop,
    output fill_req_t head,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] PTR_ONE = 1;

    typedef struct packed {
        logic [PTR_W:0] wr;
        logic [PTR_W:0] rd;
    } ptr_state_t;

    ptr_state_t s_q, s_d;
    fill_req_t  mem_q [DEPTH];

    always_comb begin
        s_d = s_q;
        if (push) s_d.wr = s_q.wr + PTR_ONE;
        if (pop)  s_d.rd = s_q.rd + PTR_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wr[PTR_W-1:0]] <= push_data;
    end

    assign empty = (s_q.wr == s_q.rd);
    assign full  = (s_q.wr[PTR_W] != s_q.rd[PTR_W]) &&
                   (s_q.wr[PTR_W-1:0] == s_q.rd[PTR_W-1:0]);
    assign head  = mem_q[s_q.rd[PTR_W-1:0]];
endmodule

// File: rtl/fill_sender.sv
module fill_sender
    import fill_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  fill_kind_e         req_kind,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [FRAME_W-1:0] req_frame,
    input  logic [OFS_W-1:0]   req_word,
    output logic               req_ready,
    input  logic               trk_full,
    output logic               trk_push,
    input  logic               rsp_busy,
    output logic               bus_valid,
    input  logic               bus_ready,
    output logic               bus_write,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [WORD_W-1:0]  bus_wdata,
    output logic [LOC_W-1:0]   wb_loc,
    input  logic [WORD_W-1:0]  wb_rdata
);
    localparam logic [OFS_W-1:0] CNT_ONE  = 1;
    localparam logic [OFS_W-1:0] CNT_LAST = OFS_W'(LINE_WORDS - 1);

    typedef struct packed {
        logic               busy;
        fill_kind_e         kind;
        logic [TAG_W-1:0]   tag;
        logic [FRAME_W-1:0] frame;
        logic [OFS_W-1:0]   word;
        logic [OFS_W-1:0]   cnt;
    } send_state_t;

    send_state_t s_q, s_d;
    logic [OFS_W-1:0] word_idx;
    logic is_wb, is_io, last_beat;

    always_comb begin
        word_idx  = s_q.word + s_q.cnt;
        is_wb     = (s_q.kind == K_WRITEBACK);
        is_io     = (s_q.kind == K_IO_LOAD);
        last_beat = is_io || (s_q.cnt == CNT_LAST);

        bus_valid = s_q.busy && !(is_wb && rsp_busy);
        bus_write = s_q.busy && is_wb;
        bus_addr  = {s_q.tag, s_q.frame, word_idx};
        wb_loc    = {s_q.frame, word_idx};
        bus_wdata = is_wb ? wb_rdata : '0;

        req_ready = !s_q.busy && !(kind_reads(req_kind) && trk_full);
        trk_push  = req_valid && req_ready && kind_reads(req_kind);

        s_d = s_q;
        if (req_valid && req_ready) begin
            s_d.busy  = 1'b1;
            s_d.kind  = req_kind;
            s_d.tag   = req_tag;
            s_d.frame = req_frame;
            s_d.word  = (req_kind == K_WRITEBACK) ? '0 : req_word;
            s_d.cnt   = '0;
        end else if (bus_valid && bus_ready) begin
            if (last_beat) s_d.busy = 1'b0;
            else           s_d.cnt  = s_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fill_receiver.sv
module fill_receiver
    import fill_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rsp_valid,
    input  logic [WORD_W-1:0]  rsp_data,
    input  fill_req_t          head,
    input  logic               trk_empty,
    output logic               trk_pop,
    output logic               fill_we,
    output logic [LOC_W-1:0]   fill_loc,
    output logic [WORD_W-1:0]  fill_wdata,
    output logic               tag_we,
    output logic [FRAME_W-1:0] tag_frame,
    output logic [TAG_W-1:0]   tag_value,
    output logic               tag_dirty,
    output logic               cpl_valid,
    output logic [WORD_W-1:0]  cpl_data,
    output logic [META_W-1:0]  cpl_meta
);
    localparam logic [OFS_W-1:0] CNT_ONE  = 1;
    localparam logic [OFS_W-1:0] CNT_LAST = OFS_W'(LINE_WORDS - 1);

    typedef struct packed {
        logic [OFS_W-1:0] cnt;
    } recv_state_t;

    recv_state_t s_q, s_d;
    logic act, is_io, is_store, first_beat, last_beat;
    logic [OFS_W-1:0] idx;

    always_comb begin
        act        = rsp_valid && !trk_empty;
        is_io      = (head.kind == K_IO_LOAD);
        is_store   = (head.kind == K_STORE_FILL);
        first_beat = (s_q.cnt == '0);
        last_beat  = is_io || (s_q.cnt == CNT_LAST);
        idx        = head.word + s_q.cnt;

        for (int b = 0; b < BE_W; b++) begin
            fill_wdata[b*8 +: 8] = (is_store && first_beat && head.sbe[b]) ?
                                   head.sdata[b*8 +: 8] : rsp_data[b*8 +: 8];
        end
        fill_we   = act && !is_io;
        fill_loc  = {head.frame, idx};

        cpl_valid = act && first_beat && (head.kind == K_LOAD_FILL || is_io);
        cpl_data  = rsp_data;
        cpl_meta  = head.meta;

        tag_we    = act && !is_io && last_beat;
        tag_frame = head.frame;
        tag_value = head.tag;
        tag_dirty = is_store;

        trk_pop   = act && last_beat;

        s_d = s_q;
        if (trk_pop)  s_d.cnt = '0;
        else if (act) s_d.cnt = s_q.cnt + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/line_fill_engine.sv
module line_fill_engine
    import fill_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [FRAME_W-1:0] req_frame,
    input  logic [OFS_W-1:0]   req_word,
    input  logic [META_W-1:0]  req_meta,
    input  logic [WORD_W-1:0]  req_sdata,
    input  logic [BE_W-1:0]    req_sbe,
    output logic               bus_valid,
    input  logic               bus_ready,
    output logic               bus_write,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [WORD_W-1:0]  bus_wdata,
    input  logic               rsp_valid,
    input  logic [WORD_W-1:0]  rsp_data,
    output logic [LOC_W-1:0]   da_addr,
    output logic               da_we,
    output logic [WORD_W-1:0]  da_wdata,
    input  logic [WORD_W-1:0]  da_rdata,
    output logic               tag_we,
    output logic [FRAME_W-1:0] tag_frame,
    output logic [TAG_W-1:0]   tag_value,
    output logic               tag_dirty,
    output logic               cpl_valid,
    output logic [WORD_W-1:0]  cpl_data,
    output logic [META_W-1:0]  cpl_meta
);
    fill_req_t        req_s, head;
    logic             trk_push, trk_pop, trk_empty, trk_full, fill_we;
    logic [LOC_W-1:0] wb_loc, fill_loc;

    assign req_s = '{kind: fill_kind_e'(req_kind), tag: req_tag, frame: req_frame,
                     word: req_word, meta: req_meta, sdata: req_sdata, sbe: req_sbe};

    fill_track_fifo #(.DEPTH(TRACK_DEPTH)) u_track (
        .clk(clk), .rst_n(rst_n), .push(trk_push), .push_data(req_s),
        .pop(trk_pop), .head(head), .empty(trk_empty), .full(trk_full)
    );

    fill_sender u_send (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_s.kind),
        .req_tag(req_tag), .req_frame(req_frame), .req_word(req_word),
        .req_ready(req_ready), .trk_full(trk_full), .trk_push(trk_push),
        .rsp_busy(rsp_valid), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wb_loc(wb_loc), .wb_rdata(da_rdata)
    );

    fill_receiver u_recv (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .head(head), .trk_empty(trk_empty), .trk_pop(trk_pop),
        .fill_we(fill_we), .fill_loc(fill_loc), .fill_wdata(da_wdata),
        .tag_we(tag_we), .tag_frame(tag_frame), .tag_value(tag_value),
        .tag_dirty(tag_dirty), .cpl_valid(cpl_valid), .cpl_data(cpl_data),
        .cpl_meta(cpl_meta)
    );

    // Response words own the shared array port; write-back reads use it otherwise.
    assign da_we   = fill_we;
    assign da_addr = fill_we ? fill_loc : wb_loc;
endmodule

// File: rtl/line_fill_engine_chk.sv
module line_fill_engine_chk
    import fill_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rsp_valid,
    input logic              da_we,
    input logic              tag_we,
    input logic              cpl_valid
);
    p_wb_yield_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |-> !rsp_valid);

    p_port_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        da_we |-> !(bus_valid && bus_write));

    p_hold_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (!bus_valid || $stable(bus_addr)));

    p_cpl_on_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> rsp_valid);

    p_tag_with_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tag_we |-> (da_we && rsp_valid));
endmodule

bind line_fill_engine line_fill_engine_chk u_chk (.*);

// File: tb/line_fill_engine_bench.sv
module line_fill_engine_bench;
    import fill_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_kind = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [FRAME_W-1:0] req_frame = '0;
    logic [OFS_W-1:0] req_word = '0;
    logic [META_W-1:0] req_meta = '0;
    logic [WORD_W-1:0] req_sdata = '0;
    logic [BE_W-1:0] req_sbe = '0;
    logic bus_valid, bus_write, bus_ready = 1'b0;
    logic [ADDR_W-1:0] bus_addr;
    logic [WORD_W-1:0] bus_wdata;
    logic rsp_valid = 1'b0;
    logic [WORD_W-1:0] rsp_data = '0;
    logic [LOC_W-1:0] da_addr;
    logic da_we;
    logic [WORD_W-1:0] da_wdata, da_rdata;
    logic tag_we, tag_dirty, cpl_valid;
    logic [FRAME_W-1:0] tag_frame;
    logic [TAG_W-1:0] tag_value;
    logic [WORD_W-1:0] cpl_data;
    logic [META_W-1:0] cpl_meta;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] arr_word(logic [LOC_W-1:0] l);
        logic [31:0] x = 32'(l);
        return (x * 32'h0001_0003) ^ 32'h5A00_0000;
    endfunction

    function automatic logic [31:0] mem_word(logic [ADDR_W-1:0] a);
        logic [31:0] x = 32'(a);
        return (x * 32'h9E37_79B1) ^ 32'h0F0F_1234;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] sd, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = sd[b*8 +: 8];
        return r;
    endfunction

    assign da_rdata = arr_word(da_addr);

    line_fill_engine u_line_fill_engine (.*);

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic advance();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_req(input logic [1:0] k, input logic [TAG_W-1:0] t,
                            input logic [FRAME_W-1:0] f, input logic [OFS_W-1:0] w,
                            input logic [META_W-1:0] m, input logic [31:0] sd,
                            input logic [3:0] be);
        bit done = 0;
        req_kind = k; req_tag = t; req_frame = f; req_word = w;
        req_meta = m; req_sdata = sd; req_sbe = be; req_valid = 1'b1;
        while (!done) begin
            #1;
            done = req_ready;
            advance();
        end
        req_valid = 1'b0;
    endtask

    task automatic wait_beat();
        bit got = 0;
        bus_ready = 1'b1;
        while (!got) begin
            #1;
            got = bus_valid;
            advance();
        end
    endtask

    initial begin
        logic [TAG_W-1:0] tg;
        logic [FRAME_W-1:0] fr;
        logic [31:0] expw;
        int n, cyc, wbn, rj;

        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_valid, "R10 bus_valid", 64'(bus_valid), 64'(0));
        chk(!cpl_valid, "R10 cpl_valid", 64'(cpl_valid), 64'(0));
        chk(!da_we, "R10 da_we", 64'(da_we), 64'(0));
        chk(!tag_we, "R10 tag_we", 64'(tag_we), 64'(0));
        chk(req_ready, "R10 req_ready", 64'(req_ready), 64'(1));
        @(negedge clk);
        rst_n = 1'b1;
        advance();

        // R1 R4 R5 R6 R7: sweep every critical word for load and store refills
        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < LINE_WORDS; c++) begin
                logic [3:0] be;
                logic [31:0] sd;
                logic [META_W-1:0] mt;
                tg = 20'h1000 + 20'(c + k * 16);
                fr = 6'(c * 5 + k);
                be = 4'((c * 7 + 3) % 16);
                sd = 32'hDEAD_0000 | 32'(c);
                mt = 8'(c + 16 * k);
                send_req(2'(k), tg, fr, 3'(c), mt, sd, be);
                n = 0; cyc = 0;
                while (n < LINE_WORDS && cyc < 60) begin
                    bus_ready = (cyc % 3 != 2);
                    #1;
                    if (bus_valid && bus_ready) begin
                        chk(!bus_write && bus_addr == {tg, fr, 3'(c + n)}, "R1 refill beat address",
                            64'(bus_addr), 64'({tg, fr, 3'(c + n)}));
                        n++;
                    end
                    advance();
                    cyc++;
                end
                chk(n == LINE_WORDS, "R1 refill beat count", 64'(n), 64'(LINE_WORDS));
                bus_ready = 1'b0;
                for (int j = 0; j < LINE_WORDS; j++) begin
                    rsp_valid = 1'b1;
                    rsp_data = mem_word({tg, fr, 3'(c + j)});
                    #1;
                    expw = (k == 1 && j == 0) ? merge(rsp_data, sd, be) : rsp_data;
                    chk(da_we && da_addr == {fr, 3'(c + j)}, "R5 fill location",
                        64'(da_addr), 64'({fr, 3'(c + j)}));
                    chk(da_wdata == expw, k ? "R7 store merge data" : "R5 fill data",
                        64'(da_wdata), 64'(expw));
                    chk(cpl_valid == (k == 0 && j == 0), "R4 completion timing",
                        64'(cpl_valid), 64'(k == 0 && j == 0));
                    if (k == 0 && j == 0)
                        chk(cpl_data == rsp_data && cpl_meta == mt, "R4 completion data/meta",
                            64'({cpl_meta, cpl_data}), 64'({mt, rsp_data}));
                    chk(tag_we == (j == LINE_WORDS - 1), "R6 tag write timing",
                        64'(tag_we), 64'(j == LINE_WORDS - 1));
                    if (j == LINE_WORDS - 1)
                        chk(tag_frame == fr && tag_value == tg && tag_dirty == 1'(k),
                            k ? "R7 tag dirty" : "R6 tag clean",
                            64'({tag_dirty, tag_frame, tag_value}), 64'({1'(k), fr, tg}));
                    advance();
                end
                rsp_valid = 1'b0;
            end
        end

        // R2 R3: write-back interleaved with arriving refill data
        send_req(2'd0, 20'h2222, 6'd10, 3'd3, 8'h77, 32'h0, 4'h0);
        wait_beat();
        for (int i = 1; i < LINE_WORDS; i++) wait_beat();
        send_req(2'd2, 20'h3333, 6'd20, 3'd5, 8'h00, 32'h0, 4'h0);
        wbn = 0; rj = 0; cyc = 0;
        while ((wbn < LINE_WORDS || rj < LINE_WORDS) && cyc < 60) begin
            rsp_valid = (rj < LINE_WORDS) && (cyc % 2 == 0);
            rsp_data = mem_word({20'h2222, 6'd10, 3'(3 + rj)});
            bus_ready = 1'b1;
            #1;
            if (rsp_valid) begin
                chk(!bus_valid, "R3 write-back yields to response", 64'(bus_valid), 64'(0));
                chk(da_we && da_addr == {6'd10, 3'(3 + rj)}, "R3 response not blocked",
                    64'({da_we, da_addr}), 64'({1'b1, 6'd10, 3'(3 + rj)}));
                rj++;
            end else if (bus_valid) begin
                chk(bus_write && bus_addr == {20'h3333, 6'd20, 3'(wbn)} &&
                    da_addr == {6'd20, 3'(wbn)}, "R2 write-back address",
                    64'(bus_addr), 64'({20'h3333, 6'd20, 3'(wbn)}));
                chk(bus_wdata == arr_word({6'd20, 3'(wbn)}), "R2 write-back data",
                    64'(bus_wdata), 64'(arr_word({6'd20, 3'(wbn)})));
                wbn++;
            end
            advance();
            cyc++;
        end
        rsp_valid = 1'b0;
        chk(wbn == LINE_WORDS && rj == LINE_WORDS, "R3 both streams complete",
            64'({wbn, rj}), 64'({LINE_WORDS, LINE_WORDS}));

        // R8: uncached load
        send_req(2'd3, 20'h4444, 6'd33, 3'd6, 8'h5C, 32'h0, 4'h0);
        bus_ready = 1'b1;
        #1;
        chk(bus_valid && !bus_write && bus_addr == {20'h4444, 6'd33, 3'd6}, "R8 single beat address",
            64'(bus_addr), 64'({20'h4444, 6'd33, 3'd6}));
        advance();
        #1;
        chk(!bus_valid, "R8 only one beat", 64'(bus_valid), 64'(0));
        @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data = mem_word({20'h4444, 6'd33, 3'd6});
        #1;
        chk(cpl_valid && cpl_data == rsp_data && cpl_meta == 8'h5C, "R8 completion",
            64'({cpl_valid, cpl_meta, cpl_data}), 64'({1'b1, 8'h5C, rsp_data}));
        chk(!da_we && !tag_we, "R8 no array or tag write", 64'({da_we, tag_we}), 64'(0));
        advance();
        rsp_valid = 1'b0;

        // R9: fill the tracking queue to 32 outstanding reads
        for (int i = 0; i < TRACK_DEPTH; i++) begin
            send_req(2'd3, 20'h5000 + 20'(i), 6'(i), 3'(i), 8'(i + 100), 32'h0, 4'h0);
            wait_beat();
        end
        req_kind = 2'd3; req_tag = 20'h6000; req_frame = 6'd1; req_word = 3'd2;
        req_meta = 8'd200; req_valid = 1'b1;
        #1;
        chk(!req_ready, "R9 full queue holds read", 64'(req_ready), 64'(0));
        advance();
        #1;
        chk(!req_ready, "R9 still held", 64'(req_ready), 64'(0));
        @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data = 32'h1234_5678;
        #1;
        chk(cpl_valid && cpl_meta == 8'd100, "R9 oldest retires first",
            64'(cpl_meta), 64'(100));
        advance();
        rsp_valid = 1'b0;
        #1;
        chk(req_ready, "R9 space after retire", 64'(req_ready), 64'(1));
        advance();
        req_valid = 1'b0;
        wait_beat();
        bus_ready = 1'b0;
        for (int i = 1; i <= TRACK_DEPTH; i++) begin
            logic [7:0] em;
            em = (i < TRACK_DEPTH) ? 8'(i + 100) : 8'd200;
            rsp_valid = 1'b1;
            rsp_data = 32'(i);
            #1;
            chk(cpl_valid && cpl_meta == em, "R9 in-order metadata",
                64'(cpl_meta), 64'(em));
            advance();
        end
        rsp_valid = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule